// File: doc/BRIEF.md
# Completion-Chained Cascade Counter

This block is a chain of limit counters that advance by event instead of all moving together on a shared edge. Each stage has three parts: a comparator, a holding register and an incrementer. A request into a stage passes through them in a fixed order, and each part hands over to the next with a one-cycle completion pulse. The comparator samples `count == limit` on the clock edge that accepts the request. One edge later the holding register loads either zero or the incremented value, and it announces completion. The incrementer is pure logic.

Only the head stage is driven by the dot tick. Every later stage receives a request only when the stage before it completes with its wrap flag raised. Stages whose input has not changed therefore see no register activity. The chain behaves as a mixed-radix count: stage k with limit L wraps once every L+1 advances. The last stage's wrap marks the end of a full sequence.

The tick input is a valid/ready stream. A producer raises `tick_valid` and holds it until it sees `tick_ready` high at a clock edge; the tick is accepted on that edge. After accepting a tick, the head stage lowers `tick_ready` for two cycles while its handshake completes, which applies back-pressure to the tick producer. Everything runs in one clock domain, and every handshake is an enable pulse answered by a completion pulse.

Top module: `cascade_timer`

## Requirements
- R1: A tick is accepted on a rising edge where `tick_valid` and `tick_ready` are both high. `tick_ready` is low for the two cycles after that edge and high again in the third.
- R2: Two cycles after an accepted tick, `stage_done[0]` is high for one cycle.
- R3: Stage k (k ≥ 1) receives a request only in the cycle where `stage_done[k-1]` and `stage_flag[k-1]` are both high, and `stage_done[k]` pulses two cycles later.
- R4: `stage_flag[k]` is high only together with `stage_done[k]`, and exactly when that stage's count equalled `stage_limit[k]` at comparison. The count then wraps to zero; otherwise it increments by one.
- R5: A stage that receives no request produces no completion pulse.
- R6: `chain_done` pulses in the same cycle as a flagged completion of the last stage, and at no other time.
- R7: A synchronous reset clears every count and every pending handshake. After reset, `tick_ready` is high, no completion is pending, and the head stage first flags on its `stage_limit[0]+1`-th accepted tick.
- R8: With a limit of zero, a stage flags on every advance. With all limits zero, every accepted tick produces one `chain_done`.
- R9: With a limit of 2^CW−1, the head stage runs through the full count range: no flag in the first 255 ticks (CW = 8), and a flag on the 256th.
- R10: Each completion and flag output is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_valid | input | 1 | Dot tick offered to the head stage |
| tick_ready | output | 1 | Head stage can accept a tick |
| stage_limit | input | STAGES×CW | Wrap limit per stage, element k for stage k |
| stage_done | output | STAGES | Bit k pulses when stage k completes an advance |
| stage_flag | output | STAGES | Bit k pulses when stage k wraps on that completion |
| chain_done | output | 1 | Pulses when the last stage wraps |

## Verification
The properties assume that `stage_limit` changes only while the chain is idle or in reset. They also assume that a producer holds `tick_valid` until the tick is taken. The stimulus follows both rules: it loads new limits only ahead of a reset, and it drops `tick_valid` only on the cycle after an acceptance. The cascade spacing rule, that a stage is never asked to advance while still busy, is derived from the two-cycle ready gap. It is asserted rather than assumed, so stimulus with back-to-back valid ticks and all limits at zero presses directly on it.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned CT_STAGES = 4;
  localparam int unsigned CT_CW     = 8;

  // Result handed on by a holding register at the end of an advance
  typedef struct packed {
    logic done;
    logic wrap;
  } ct_event_t;
endpackage

// File: rtl/ct_inc.sv
module ct_inc #(
  parameter int unsigned CW = 8
) (
  input  logic [CW-1:0] cur,
  output logic [CW-1:0] nxt
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  assign nxt = cur + ONE;
endmodule

// File: rtl/ct_cmp.sv
module ct_cmp #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] cur,
  input  logic [CW-1:0] lim,
  output logic          hit_q,
  output logic          fin_q
);
  // Comparison is captured on the accepting edge; fin_q hands over to the register
  always_ff @(posedge clk) begin
    if (rst) begin
      fin_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      fin_q <= start;
      if (start) hit_q <= (cur == lim);
    end
  end
endmodule

// File: rtl/ct_hold.sv
module ct_hold
  import ct_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          hit,
  input  logic [CW-1:0] nxt,
  output logic [CW-1:0] val_q,
  output ct_event_t     ev_q
);
  // Register moves only when the comparator reports completion
  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      ev_q  <= '0;
    end else begin
      ev_q.done <= load;
      ev_q.wrap <= load & hit;
      if (load) val_q <= hit ? '0 : nxt;
    end
  end
endmodule

// File: rtl/ct_stage.sv
module ct_stage
  import ct_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [CW-1:0] lim,
  output logic          busy,
  output logic          done,
  output logic          wrap
);
  logic [CW-1:0] cur;
  logic [CW-1:0] nxt;
  logic          start;
  logic          hit;
  logic          cmp_fin;
  ct_event_t     ev;

  assign busy  = cmp_fin | ev.done;
  assign start = req & ~busy;

  ct_cmp #(.CW(CW)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .cur   (cur),
    .lim   (lim),
    .hit_q (hit),
    .fin_q (cmp_fin)
  );

  ct_inc #(.CW(CW)) u_inc (
    .cur (cur),
    .nxt (nxt)
  );

  ct_hold #(.CW(CW)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .load  (cmp_fin),
    .hit   (hit),
    .nxt   (nxt),
    .val_q (cur),
    .ev_q  (ev)
  );

  assign done = ev.done;
  assign wrap = ev.wrap;
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import ct_pkg::*;
#(
  parameter int unsigned STAGES = CT_STAGES,
  parameter int unsigned CW     = CT_CW
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_valid,
  output logic                       tick_ready,
  input  logic [STAGES-1:0][CW-1:0]  stage_limit,
  output logic [STAGES-1:0]          stage_done,
  output logic [STAGES-1:0]          stage_flag,
  output logic                       chain_done
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stage_req;
  logic [STAGES-1:0] stage_busy;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stage_req[g] = tick_valid;
    end else begin : g_link
      assign stage_req[g] = stage_done[g-1] & stage_flag[g-1];
    end

    ct_stage #(.CW(CW)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .req  (stage_req[g]),
      .lim  (stage_limit[g]),
      .busy (stage_busy[g]),
      .done (stage_done[g]),
      .wrap (stage_flag[g])
    );
  end

  assign tick_ready = ~stage_busy[0];
  assign chain_done = stage_flag[LAST];
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
  parameter int unsigned STAGES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_valid,
  input logic              tick_ready,
  input logic [STAGES-1:0] stage_done,
  input logic [STAGES-1:0] stage_flag,
  input logic              chain_done,
  input logic [STAGES-1:0] stage_req,
  input logic [STAGES-1:0] stage_busy
);
  a_r1_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (tick_valid && tick_ready) |=> !tick_ready);

  a_r2_head_done_after_accept: assert property (@(posedge clk) disable iff (rst)
    stage_done[0] |-> $past(tick_valid && tick_ready, 2));

  for (genvar k = 1; k < STAGES; k++) begin : g_r3
    a_r3_done_follows_flag: assert property (@(posedge clk) disable iff (rst)
      stage_done[k] |-> $past(stage_flag[k-1], 2));
  end

  a_r4_flag_with_done: assert property (@(posedge clk) disable iff (rst)
    (stage_flag & ~stage_done) == '0);

  a_r5_no_request_while_busy: assert property (@(posedge clk) disable iff (rst)
    (stage_req & stage_busy & ~{{(STAGES-1){1'b0}}, 1'b1}) == '0);

  a_r6_chain_after_prior_wrap: assert property (@(posedge clk) disable iff (rst)
    chain_done |-> $past(stage_flag[STAGES-2], 2));

  a_r7_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (stage_done == '0 && !chain_done));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (stage_done & $past(stage_done)) == '0);
endmodule

bind cascade_timer cascade_timer_chk #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_valid (tick_valid),
  .tick_ready (tick_ready),
  .stage_done (stage_done),
  .stage_flag (stage_flag),
  .chain_done (chain_done),
  .stage_req  (stage_req),
  .stage_busy (stage_busy)
);

// File: tb/cascade_timer_tb.sv
module cascade_timer_tb;
  localparam int S    = 4;
  localparam int W    = 8;
  localparam int RING = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 tick_valid = 1'b0;
  logic                 tick_ready;
  logic [S-1:0][W-1:0]  lim = '0;
  logic [S-1:0]         sdone;
  logic [S-1:0]         sflag;
  logic                 cdone;

  always #5 clk = ~clk;

  cascade_timer #(.STAGES(S), .CW(W)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .tick_valid  (tick_valid),
    .tick_ready  (tick_ready),
    .stage_limit (lim),
    .stage_done  (sdone),
    .stage_flag  (sflag),
    .chain_done  (cdone)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy_until = -10;
  int acc_count = 0;
  int chain_seen = 0;
  int flag0_seen = 0;
  int first_flag_acc = -1;
  bit acc_last = 1'b0;
  int mcnt[S];
  logic [S-1:0] e_done[RING];
  logic [S-1:0] e_flag[RING];
  logic         e_chain[RING];
  logic [15:0]  lf = 16'hACE1;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < S; k++) mcnt[k] = 0;
    for (int r = 0; r < RING; r++) begin
      e_done[r]  = '0;
      e_flag[r]  = '0;
      e_chain[r] = 1'b0;
    end
    busy_until = -10;
  endtask

  // Behavioural mixed-radix model: schedule the events one accepted tick causes
  task automatic accept();
    bit go = 1'b1;
    acc_count++;
    for (int k = 0; k < S; k++) begin
      if (go) begin
        bit w = (mcnt[k] == int'(lim[k]));
        int slot = (cyc + 2 + 2 * k) % RING;
        mcnt[k] = w ? 0 : mcnt[k] + 1;
        e_done[slot][k] = 1'b1;
        e_flag[slot][k] = w;
        if (k == S - 1 && w) e_chain[slot] = 1'b1;
        go = w;
      end
    end
    busy_until = cyc + 2;
  endtask

  task automatic step(bit want);
    int s;
    @(negedge clk);
    s = cyc % RING;
    for (int k = 0; k < S; k++) begin
      chk(e_done[s][k] ? (k == 0 ? "R2" : "R3") : "R5", $sformatf("stage_done[%0d]", k),
          int'(sdone[k]), int'(e_done[s][k]));
      chk("R4", $sformatf("stage_flag[%0d]", k), int'(sflag[k]), int'(e_flag[s][k]));
    end
    chk("R6", "chain_done", int'(cdone), int'(e_chain[s]));
    if (!rst) chk("R1", "tick_ready", int'(tick_ready), int'(cyc > busy_until));
    e_done[s]  = '0;
    e_flag[s]  = '0;
    e_chain[s] = 1'b0;
    chain_seen += int'(cdone);
    flag0_seen += int'(sflag[0]);
    if (sflag[0] && first_flag_acc < 0) first_flag_acc = acc_count;
    if (acc_last) tick_valid = 1'b0;
    acc_last = 1'b0;
    if (rst) tick_valid = 1'b0;
    else if (!tick_valid) tick_valid = want;
    if (!rst && tick_valid && tick_ready) begin
      accept();
      acc_last = 1'b1;
    end
    cyc++;
  endtask

  task automatic apply_reset(int n);
    rst = 1'b1;
    tick_valid = 1'b0;
    acc_last = 1'b0;
    clear_model();
    repeat (n) step(1'b0);
    rst = 1'b0;
    acc_count = 0;
    chain_seen = 0;
    flag0_seen = 0;
    first_flag_acc = -1;
  endtask

  function automatic bit next_want();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0] | lf[5];
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    clear_model();
    lim[0] = 8'd2; lim[1] = 8'd1; lim[2] = 8'd3; lim[3] = 8'd0;
    apply_reset(3);
    // R7: idle state straight after reset
    chk("R7", "tick_ready after reset", int'(tick_ready), 1);
    chk("R7", "stage_done after reset", int'(sdone), 0);

    // Mixed limits, irregular offers
    for (int i = 0; i < 400; i++) step(next_want());

    // R7: reset with handshakes still in flight
    for (int i = 0; i < 20; i++) step(1'b1);
    apply_reset(2);
    chk("R7", "tick_ready after mid-run reset", int'(tick_ready), 1);
    while (first_flag_acc < 0) step(1'b1);
    chk("R7", "ticks to first head wrap", first_flag_acc, int'(lim[0]) + 1);
    repeat (10) step(1'b0);

    // R8: all limits zero, back-to-back offers
    lim = '0;
    apply_reset(2);
    for (int i = 0; i < 150; i++) step(1'b1);
    repeat (10) step(1'b0);
    chk("R8", "chain_done count vs ticks", chain_seen, acc_count);

    // R9: full-range head limit
    lim = '0;
    lim[0] = 8'hFF;
    apply_reset(2);
    while (acc_count < 255) step(1'b1);
    repeat (6) step(1'b0);
    chk("R9", "head flags after 255 ticks", flag0_seen, 0);
    while (acc_count < 256) step(1'b1);
    repeat (12) step(1'b0);
    chk("R9", "head flags after 256 ticks", flag0_seen, 1);
    chk("R9", "chain_done after 256 ticks", chain_seen, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule